// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches one asynchronous external pin and turns it into an interrupt request for a CPU. A 2-bit sense field chooses how the pin is interpreted: as a low level, as any change, as a falling edge or as a rising edge. The pin first passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier, and the raw pin is never used for this.

Edge and change detections set a sticky pending flag. Software clears the flag by writing a 1 to it, or the CPU clears it with an acknowledge pulse. In low-level mode nothing is stored, and the condition lasts only while the synchronized pin stays low. The request to the CPU is the active condition, qualified by a per-source enable and a global interrupt enable. A separate wake output reports the active condition without these enables, so that a sleep controller can restart a stopped clock domain.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control register reads 0x00, which selects low-level mode. The pending flag, `irq_o` and `wake_o` are 0 while the pin is high.
- R2: The sense field is bits 7:6 of the 8-bit control register. The encoding is 00 low level, 01 any change, 10 falling edge and 11 rising edge. A write stores bits 7:6, and bits 5:0 always read as 0.
- R3: The pin passes through two synchronizer flops. A pin change made between two rising clock edges produces no level request until the second following edge, and sets the flag on the third following edge.
- R4: In falling-edge mode (10) a high-to-low transition sets the flag, and a low-to-high transition leaves it clear.
- R5: In rising-edge mode (11) a low-to-high transition sets the flag, and a high-to-low transition leaves it clear.
- R6: In any-change mode (01) transitions in both directions set the flag.
- R7: In an edge mode, a low pulse that lasts one clock period sets the flag.
- R8: In low-level mode (00) the flag never sets. `irq_o` is 1 while the synchronized pin is low and returns to 0 two edges after the pin goes high.
- R9: `irq_o` is 1 only when `gie_i` and `mask_i` are both 1 and the mode's condition (flag, or low level) holds.
- R10: The flag stays set until `ack_i` is pulsed, or until `flag_we_i` is asserted with `flag_wdata_i`=1. A write with `flag_wdata_i`=0 leaves it set. A new detection in the same cycle as a clear takes priority and keeps the flag set.
- R11: `wake_o` is 1 whenever the flag is set or the low-level condition holds, regardless of `gie_i` and `mask_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external pin |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read data |
| gie_i | input | 1 | Global interrupt enable |
| mask_i | input | 1 | Per-source enable |
| ack_i | input | 1 | Acknowledge pulse from the CPU; clears the flag |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data (1 clears) |
| flag_o | output | 1 | Pending flag |
| irq_o | output | 1 | Qualified request to the CPU |
| wake_o | output | 1 | Unqualified wake request |

## Verification
A wrong sense field shows on `ctrl_rdata_o` at once. It also shows on `flag_o` three edges after the next pin transition, because that transition either sets the flag or leaves it clear in the wrong direction. A synchronizer with the wrong depth moves the flag and level response by one edge, and the directed tests sample at exactly the second and third edges to catch this. A flag that fails to stay set, or that clears when it should not, shows directly on `flag_o`, `irq_o` and `wake_o` in the cycle after the acknowledge or the write.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_mode_e;

  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= IDLE_VAL;
        else if (i == 0) stg_q[i] <= d_i;
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_s_i,
  input  sense_mode_e mode_i,
  output logic        set_o,
  output logic        level_o
);
  logic prev_q;
  logic fall, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_VAL;
    else prev_q <= pin_s_i;
  end

  assign fall = prev_q & ~pin_s_i;
  assign rise = ~prev_q & pin_s_i;

  always_comb begin
    set_o   = 1'b0;
    level_o = 1'b0;
    unique case (mode_i)
      SENSE_LOW:  level_o = ~pin_s_i;
      SENSE_ANY:  set_o   = fall | rise;
      SENSE_FALL: set_o   = fall;
      SENSE_RISE: set_o   = rise;
      default:    ;
    endcase
  end

  // R8
  low_mode_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_LOW) |-> !set_o);
  // R4
  fall_mode_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_FALL && set_o) |-> !pin_s_i);
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // a fresh detection outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R10
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTRL_W      = 8,
  parameter logic        PIN_IDLE    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              gie_i,
  input  logic              mask_i,
  input  logic              ack_i,
  input  logic              flag_we_i,
  input  logic              flag_wdata_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned MODE_MSB = CTRL_W - 1;
  localparam int unsigned MODE_LSB = CTRL_W - MODE_W;

  logic [MODE_W-1:0] mode_q;
  sense_mode_e       mode;
  logic              pin_s, set, level, flag, clr;
  logic              unused_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (ctrl_we_i) mode_q <= ctrl_wdata_i[MODE_MSB:MODE_LSB];
  end

  assign unused_wdata = ^ctrl_wdata_i[MODE_LSB-1:0];
  assign mode         = sense_mode_e'(mode_q);
  assign ctrl_rdata_o = {mode_q, {MODE_LSB{1'b0}}};

  ext_irq_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(PIN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  ext_irq_detect #(.IDLE_VAL(PIN_IDLE)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_s_i(pin_s),
    .mode_i (mode),
    .set_o  (set),
    .level_o(level)
  );

  assign clr = ack_i | (flag_we_i & flag_wdata_i);

  ext_irq_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set),
    .clr_i (clr),
    .flag_o(flag)
  );

  assign flag_o = flag;
  assign wake_o = flag | level;
  assign irq_o  = gie_i & mask_i & (flag | level);

  // R11
  irq_implies_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);
  // R9
  irq_needs_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && mask_i));
  // R2
  ctrl_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[MODE_LSB-1:0] == '0);
  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_rdata_o));
endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       gie = 1'b1, mask = 1'b1, ack = 1'b0;
  logic       flag_we = 1'b0, flag_wdata = 1'b0;
  logic       flag, irq, wake;
  int         n_checks = 0, n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .gie_i(gie), .mask_i(mask), .ack_i(ack),
    .flag_we_i(flag_we), .flag_wdata_i(flag_wdata),
    .flag_o(flag), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    ctrl_we = 1'b1; ctrl_wdata = {m, 6'b101010};
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_rdata, 8'h00);
    check("R1 flag", {7'b0, flag}, 8'h0);
    check("R1 irq", {7'b0, irq}, 8'h0);
    check("R1 wake", {7'b0, wake}, 8'h0);
  endtask

  task automatic t_ctrl();
    set_mode(2'b11);
    check("R2 readback 11", ctrl_rdata, 8'hC0);
    set_mode(2'b01);
    check("R2 readback 01", ctrl_rdata, 8'h40);
  endtask

  task automatic t_level();
    set_mode(2'b00);
    pin = 1'b0;
    step(1);
    check("R3 level after one edge", {7'b0, irq}, 8'h0);
    step(1);
    check("R8 level irq", {7'b0, irq}, 8'h1);
    check("R11 level wake", {7'b0, wake}, 8'h1);
    step(2);
    check("R8 no flag", {7'b0, flag}, 8'h0);
    pin = 1'b1;
    step(1);
    check("R8 still low one edge", {7'b0, irq}, 8'h1);
    step(1);
    check("R8 released", {7'b0, irq}, 8'h0);
    check("R8 flag after release", {7'b0, flag}, 8'h0);
  endtask

  task automatic t_fall();
    set_mode(2'b10);
    pin = 1'b0;
    step(2);
    check("R3 flag not at 2nd edge", {7'b0, flag}, 8'h0);
    step(1);
    check("R3 R4 fall flag", {7'b0, flag}, 8'h1);
    check("R9 irq", {7'b0, irq}, 8'h1);
    do_ack();
    check("R10 ack clears", {7'b0, flag}, 8'h0);
    pin = 1'b1;
    step(4);
    check("R4 rise ignored", {7'b0, flag}, 8'h0);
  endtask

  task automatic t_rise();
    set_mode(2'b11);
    pin = 1'b0;
    step(4);
    check("R5 fall ignored", {7'b0, flag}, 8'h0);
    pin = 1'b1;
    step(3);
    check("R5 rise flag", {7'b0, flag}, 8'h1);
    do_ack();
  endtask

  task automatic t_any();
    set_mode(2'b01);
    pin = 1'b0;
    step(3);
    check("R6 fall in any", {7'b0, flag}, 8'h1);
    do_ack();
    check("R6 cleared", {7'b0, flag}, 8'h0);
    pin = 1'b1;
    step(3);
    check("R6 rise in any", {7'b0, flag}, 8'h1);
    do_ack();
  endtask

  task automatic t_pulse();
    set_mode(2'b10);
    pin = 1'b0;
    step(1);
    pin = 1'b1;
    step(3);
    check("R7 one-clock pulse", {7'b0, flag}, 8'h1);
  endtask

  task automatic t_enables();
    gie = 1'b0;
    #1;
    check("R9 gie off irq", {7'b0, irq}, 8'h0);
    check("R11 gie off wake", {7'b0, wake}, 8'h1);
    gie = 1'b1; mask = 1'b0;
    #1;
    check("R9 mask off irq", {7'b0, irq}, 8'h0);
    check("R11 mask off wake", {7'b0, wake}, 8'h1);
    mask = 1'b1;
    #1;
    check("R9 both on", {7'b0, irq}, 8'h1);
  endtask

  task automatic t_w1c();
    flag_we = 1'b1; flag_wdata = 1'b0;
    step(1);
    check("R10 write 0 keeps", {7'b0, flag}, 8'h1);
    flag_wdata = 1'b1;
    step(1);
    flag_we = 1'b0; flag_wdata = 1'b0;
    check("R10 write 1 clears", {7'b0, flag}, 8'h0);
    check("R10 irq after clear", {7'b0, irq}, 8'h0);
  endtask

  task automatic t_set_wins();
    set_mode(2'b10);
    pin = 1'b0;
    step(2);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    check("R10 set beats ack", {7'b0, flag}, 8'h1);
    do_ack();
    check("R10 later ack", {7'b0, flag}, 8'h0);
    pin = 1'b1;
    step(3);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_ctrl();
    t_level();
    t_fall();
    t_rise();
    t_any();
    t_pulse();
    t_enables();
    t_w1c();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule